// File: doc/BRIEF.md
# Multi-Core Register Access Router

This block joins one host register port to four identical register-file cores that share a single address map. Two small control registers live inside the router. One is a write-enable mask at sub-address 0xFE. The other is a read-select mask at sub-address 0xFF. Each mask has one bit per core. A host write to any other address goes out in the same cycle, with a shared address and data, to every core whose write-enable bit is set. One write can therefore configure several cores at once.

A host read of an ordinary address is served by exactly one core. When several read-select bits are set, the core with the lowest set bit number answers. The router answers reads of its own two control registers. Writing either control register clears the other one, so a broadcast-write setup and a read setup are never active together.

A read is handled by a three-state sequencer. `ST_IDLE` accepts requests. An accepted read moves it to `ST_FETCH`, where the chosen core's read strobe and the latched address are driven and the answer is captured. It then moves to `ST_REPLY`, where `host_rvalid` is high for one cycle, and goes back to `ST_IDLE`. The transitions are: IDLE to FETCH on an accepted read, FETCH to REPLY always, and REPLY to IDLE always. Writes finish in `ST_IDLE` without changing state. A read and a write in the same idle cycle are treated as a write only.

Top module: `core_access_router`

## Requirements
- R1: After reset both control registers are 0x00, `host_busy` is 0 and `host_rvalid` is 0.
- R2: A host write accepted in idle to any address other than 0xFE/0xFF drives `core_we` equal to the write-enable mask in that same cycle, with `core_addr` = `host_addr` and `core_wdata` = `host_wdata`.
- R3: A core whose write-enable bit is 0 never has its contents changed by a write.
- R4: Only the low four bits written to 0xFE or 0xFF are stored, and bits 7..4 read back as 0.
- R5: Writing any value to 0xFE sets the read-select mask (0xFF) to 0x00.
- R6: Writing any value to 0xFF sets the write-enable mask (0xFE) to 0x00.
- R7: A read of an ordinary address asserts `core_re` for only the lowest-numbered core whose read-select bit is 1, in the cycle after acceptance, and returns that core's data.
- R8: A read of an ordinary address while the read-select mask is 0 returns 0x00 and asserts no `core_re`.
- R9: Reads of 0xFE and 0xFF are answered from the router's own registers, with no `core_re`, and writes to them drive no `core_we`.
- R10: `host_rvalid` is high for exactly one cycle, two clock edges after the edge that accepts a read. `host_busy` is high in between, and requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host sub-address |
| host_wdata | input | DATA_W | Host write data |
| host_busy | output | 1 | Read in progress; requests ignored |
| host_rvalid | output | 1 | Read data valid, one cycle |
| host_rdata | output | DATA_W | Read data |
| core_we | output | N_CORES | Per-core write strobes |
| core_re | output | N_CORES | Per-core read strobes |
| core_addr | output | ADDR_W | Shared core address |
| core_wdata | output | DATA_W | Shared core write data |
| core_rdata | input | N_CORES*DATA_W | Core read data, core i in bits [i*DATA_W +: DATA_W] |

## Verification
Each core is preloaded with values that differ from every other core, so any read shows which core answered. Directed cases write masks with mixed bit patterns, such as 0x5 for the write-enable mask and 0xC for the read-select mask. These show whether the broadcast reached only the enabled cores and whether the lowest set bit, not some other set bit, won the read. Back-to-back writes to the two control registers check the mutual clearing rule in both directions. A write made while a read is in flight checks that requests during the busy window are dropped. A long seeded random mix of mask writes, data writes and reads is compared against a bench model, and a full scan of the core arrays at the end catches any write that leaked to a disabled core.

// File: rtl/car_pkg.sv
package car_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } car_state_e;

endpackage

// File: rtl/car_ctrl_regs.sv
module car_ctrl_regs #(
    parameter int                N_CORES = 4,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] WE_ADDR = 'hFE,
    parameter logic [ADDR_W-1:0] RS_ADDR = 'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [N_CORES-1:0] we_mask,
    output logic [N_CORES-1:0] rs_mask,
    output logic               wr_hit,
    output logic               rd_hit,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int PAD_W = DATA_W - N_CORES;

    logic wr_is_we;
    logic wr_is_rs;

    assign wr_is_we = (wr_addr == WE_ADDR);
    assign wr_is_rs = (wr_addr == RS_ADDR);
    assign wr_hit   = wr_is_we || wr_is_rs;
    assign rd_hit   = (rd_addr == WE_ADDR) || (rd_addr == RS_ADDR);

    // Writing one mask clears the other
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_mask <= '0;
            rs_mask <= '0;
        end else if (wr_en && wr_is_we) begin
            we_mask <= wdata[N_CORES-1:0];
            rs_mask <= '0;
        end else if (wr_en && wr_is_rs) begin
            rs_mask <= wdata[N_CORES-1:0];
            we_mask <= '0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == WE_ADDR) begin
            rd_data = {{PAD_W{1'b0}}, we_mask};
        end else if (rd_addr == RS_ADDR) begin
            rd_data = {{PAD_W{1'b0}}, rs_mask};
        end
    end

endmodule

// File: rtl/car_read_pick.sv
module car_read_pick #(
    parameter int N_CORES = 4
) (
    input  logic [N_CORES-1:0] sel_mask,
    output logic [N_CORES-1:0] grant,
    output logic               any_sel
);

    // lower_set[i] is high when some bit below i is set
    logic [N_CORES:0] lower_set;

    assign lower_set[0] = 1'b0;

    for (genvar i = 0; i < N_CORES; i++) begin : g_chain
        assign lower_set[i+1] = lower_set[i] | sel_mask[i];
        assign grant[i]       = sel_mask[i] & ~lower_set[i];
    end

    assign any_sel = lower_set[N_CORES];

endmodule

// File: rtl/car_rd_seq.sv
module car_rd_seq
    import car_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_go,
    output logic idle,
    output logic fetch,
    output logic reply
);

    car_state_e state_q;
    car_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_go) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle  = 1'b0;
        fetch = 1'b0;
        reply = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle  = 1'b1;
            ST_FETCH: fetch = 1'b1;
            ST_REPLY: reply = 1'b1;
            default:  idle  = 1'b1;
        endcase
    end

endmodule

// File: rtl/core_access_router.sv
module core_access_router #(
    parameter int                N_CORES = 4,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] WE_ADDR = 'hFE,
    parameter logic [ADDR_W-1:0] RS_ADDR = 'hFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic                        host_busy,
    output logic                        host_rvalid,
    output logic [DATA_W-1:0]           host_rdata,
    output logic [N_CORES-1:0]          core_we,
    output logic [N_CORES-1:0]          core_re,
    output logic [ADDR_W-1:0]           core_addr,
    output logic [DATA_W-1:0]           core_wdata,
    input  logic [N_CORES*DATA_W-1:0]   core_rdata
);

    logic               idle;
    logic               fetch;
    logic               reply;
    logic               wr_go;
    logic               rd_go;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [N_CORES-1:0] we_mask;
    logic [N_CORES-1:0] rs_mask;
    logic               wr_hit;
    logic               rd_hit;
    logic [DATA_W-1:0]  ctrl_rdata;
    logic [N_CORES-1:0] grant;
    logic               any_sel;
    logic [DATA_W-1:0]  core_pick;

    assign wr_go = host_wr && idle;
    assign rd_go = host_rd && !host_wr && idle;

    car_rd_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_go (rd_go),
        .idle  (idle),
        .fetch (fetch),
        .reply (reply)
    );

    car_ctrl_regs #(
        .N_CORES (N_CORES),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WE_ADDR (WE_ADDR),
        .RS_ADDR (RS_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .wr_addr (host_addr),
        .wdata   (host_wdata),
        .rd_addr (addr_q),
        .we_mask (we_mask),
        .rs_mask (rs_mask),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .rd_data (ctrl_rdata)
    );

    car_read_pick #(
        .N_CORES (N_CORES)
    ) u_pick (
        .sel_mask (rs_mask),
        .grant    (grant),
        .any_sel  (any_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (rd_go) begin
            addr_q <= host_addr;
        end
    end

    // Grant is one-hot, so an OR of masked slices selects one core
    always_comb begin
        core_pick = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (grant[i]) begin
                core_pick = core_pick | core_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (fetch) begin
            if (rd_hit) begin
                rdata_q <= ctrl_rdata;
            end else if (any_sel) begin
                rdata_q <= core_pick;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign core_we     = (wr_go && !wr_hit) ? we_mask : '0;
    assign core_re     = (fetch && !rd_hit) ? grant : '0;
    assign core_addr   = fetch ? addr_q : host_addr;
    assign core_wdata  = host_wdata;
    assign host_busy   = !idle;
    assign host_rvalid = reply;
    assign host_rdata  = rdata_q;

endmodule

// File: rtl/car_checker.sv
module car_checker #(
    parameter int                N_CORES = 4,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] WE_ADDR = 'hFE,
    parameter logic [ADDR_W-1:0] RS_ADDR = 'hFF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               host_rd,
    input logic [ADDR_W-1:0]  host_addr,
    input logic               host_busy,
    input logic               host_rvalid,
    input logic [N_CORES-1:0] core_we,
    input logic [N_CORES-1:0] core_re,
    input logic [N_CORES-1:0] we_mask,
    input logic [N_CORES-1:0] rs_mask
);

    logic [N_CORES-1:0] re_below;
    logic               ctrl_addr;

    assign re_below  = core_re - {{(N_CORES-1){1'b0}}, 1'b1};
    assign ctrl_addr = (host_addr == WE_ADDR) || (host_addr == RS_ADDR);

    p_we_needs_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we != '0) |-> (host_wr && !host_busy));

    p_we_within_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we & ~we_mask) == '0);

    p_clear_rs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_busy && host_addr == WE_ADDR) |=> (rs_mask == '0));

    p_clear_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_busy && host_addr == RS_ADDR) |=> (we_mask == '0));

    p_re_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_re));

    p_re_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_re != '0) |-> (((core_re & rs_mask) == core_re) && ((re_below & rs_mask) == '0)));

    p_ctrl_wr_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ctrl_addr) |-> (core_we == '0));

    p_reply_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !host_busy) |=> ##1 host_rvalid);

    p_rvalid_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

endmodule

bind core_access_router car_checker #(
    .N_CORES (N_CORES),
    .ADDR_W  (ADDR_W),
    .WE_ADDR (WE_ADDR),
    .RS_ADDR (RS_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_busy   (host_busy),
    .host_rvalid (host_rvalid),
    .core_we     (core_we),
    .core_re     (core_re),
    .we_mask     (we_mask),
    .rs_mask     (rs_mask)
);

// File: tb/core_access_router_tb.sv
`timescale 1ns/1ps
module core_access_router_tb;

    localparam int NC = 4;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy;
    logic          host_rvalid;
    logic [DW-1:0] host_rdata;
    logic [NC-1:0] core_we;
    logic [NC-1:0] core_re;
    logic [AW-1:0] core_addr;
    logic [DW-1:0] core_wdata;
    logic [NC*DW-1:0] core_rdata;

    logic [DW-1:0] mem     [NC][DEPTH];
    logic [DW-1:0] exp_mem [NC][DEPTH];
    logic [NC-1:0] exp_we = '0;
    logic [NC-1:0] exp_rs = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    core_access_router u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_busy   (host_busy),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .core_we     (core_we),
        .core_re     (core_re),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .core_rdata  (core_rdata)
    );

    function automatic logic [DW-1:0] seed_val(int c, int a);
        return DW'((c * 67 + a * 13 + 5) & 8'hFF);
    endfunction

    // Core models: plain arrays, combinational read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++)
                for (int a = 0; a < DEPTH; a++)
                    mem[c][a] <= seed_val(c, a);
        end else begin
            for (int c = 0; c < NC; c++)
                if (core_we[c]) mem[c][core_addr] <= core_wdata;
        end
    end

    for (genvar g = 0; g < NC; g++) begin : g_core
        assign core_rdata[g*DW +: DW] = mem[g][core_addr];
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_ctrl(logic [AW-1:0] a);
        return (a == 8'hFE) || (a == 8'hFF);
    endfunction

    function automatic logic [NC-1:0] lowest(logic [NC-1:0] m);
        for (int i = 0; i < NC; i++)
            if (m[i]) return NC'(1 << i);
        return '0;
    endfunction

    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
        if (a == 8'hFE) return DW'(exp_we);
        if (a == 8'hFF) return DW'(exp_rs);
        for (int i = 0; i < NC; i++)
            if (exp_rs[i]) return exp_mem[i][a];
        return '0;
    endfunction

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        #0.5;
        if (is_ctrl(a)) begin
            check(core_we == '0, "R9", "core_we on control write", core_we, 0);
        end else begin
            check(core_we == exp_we, "R2", "core_we mask", core_we, exp_we);
            check(core_addr == a && core_wdata == d, "R2", "core addr/data",
                  {core_addr, core_wdata}, {a, d});
        end
        @(posedge clk);
        if (a == 8'hFE) begin
            exp_we = d[NC-1:0]; exp_rs = '0;
        end else if (a == 8'hFF) begin
            exp_rs = d[NC-1:0]; exp_we = '0;
        end else begin
            for (int i = 0; i < NC; i++)
                if (exp_we[i]) exp_mem[i][a] = d;
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(logic [AW-1:0] a, bit poke, string req);
        logic [DW-1:0] e;
        logic [NC-1:0] ere;
        e   = exp_read(a);
        ere = is_ctrl(a) ? '0 : lowest(exp_rs);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        check(host_busy == 1'b1, "R10", "busy during fetch", host_busy, 1);
        check(core_re == ere, is_ctrl(a) ? "R9" : (exp_rs == '0 ? "R8" : "R7"),
              "core_re", core_re, ere);
        if (poke) begin
            host_wr = 1'b1; host_addr = 8'h20; host_wdata = 8'h77;
            #0.5;
            check(core_we == '0, "R10", "write while busy", core_we, 0);
        end
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        check(host_rvalid == 1'b1, "R10", "rvalid two edges after accept", host_rvalid, 1);
        check(host_rdata == e, req, "read data", host_rdata, e);
        @(posedge clk);
        @(negedge clk);
        check(host_rvalid == 1'b0 && host_busy == 1'b0, "R10", "single rvalid pulse",
              {host_rvalid, host_busy}, 0);
    endtask

    initial begin
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < DEPTH; a++)
                exp_mem[c][a] = seed_val(c, a);
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(host_busy == 1'b0 && host_rvalid == 1'b0, "R1", "reset outputs",
              {host_busy, host_rvalid}, 0);
        rst_n = 1'b1;
        do_read(8'hFE, 1'b0, "R1");
        do_read(8'hFF, 1'b0, "R1");
        do_read(8'h10, 1'b0, "R8");
        // No core enabled: write must land nowhere
        do_write(8'h11, 8'h3C);
        do_write(8'hFE, 8'hF5);
        do_read(8'hFE, 1'b0, "R4");
        do_write(8'h10, 8'hAA);
        do_write(8'hFF, 8'hEC);
        do_read(8'hFF, 1'b0, "R4");
        do_read(8'hFE, 1'b0, "R6");
        do_read(8'h10, 1'b0, "R7");
        do_read(8'h11, 1'b1, "R7");
        do_write(8'hFF, 8'h0A);
        do_read(8'h10, 1'b0, "R7");
        do_write(8'hFE, 8'h00);
        do_read(8'hFF, 1'b0, "R5");
        do_read(8'h20, 1'b0, "R8");
        do_write(8'hFE, 8'h0F);
        do_write(8'h30, 8'h5A);
        do_write(8'hFF, 8'h08);
        do_read(8'h30, 1'b0, "R2");

        for (int n = 0; n < 400; n++) begin
            int op;
            logic [AW-1:0] a;
            op = int'($urandom_range(0, 99));
            a  = AW'($urandom_range(0, 63));
            if (op < 15)      do_write(8'hFE, DW'($urandom));
            else if (op < 27) do_write(8'hFF, DW'($urandom));
            else if (op < 60) do_write(a, DW'($urandom));
            else if (op < 65) do_read(op[0] ? 8'hFE : 8'hFF, 1'b0, "R9");
            else              do_read(a, op[1], "R7");
        end

        for (int c = 0; c < NC; c++)
            for (int a = 0; a < DEPTH; a++)
                if (mem[c][a] !== exp_mem[c][a])
                    check(1'b0, "R3", "core contents", mem[c][a], exp_mem[c][a]);
        check(1'b1, "R3", "core contents scan", 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule